// File: doc/BRIEF.md
# SerDes Control Register Bridge

This block is a hardware master that reads and writes the internal control registers of a SerDes PHY. Those registers are not directly addressable. Every PHY register access goes through a memory-mapped window: a page-select word is written first, and then a data access is made at an offset inside the window. Inside the PHY, three registers form a command interface: control, address and data. The block sequences all of this. It polls a busy flag, loads the target address, moves the data and starts the operation. A client only presents a port number, a PHY register address, write data and a read/write flag.

A per-port table holds a 5-bit PHY device number and a lane number for each port. The host loads this table through a write strobe. The device number goes into the page-select word. The lane moves the target register into that lane's block of the PHY address space, at 0x100 per lane. Only one request is in flight at a time. Completion is signalled by a one-cycle `done` strobe, which carries read data for reads. A busy flag that never clears is cut off by a programmable poll limit, and this raises a timeout error.

Top module: `phy_cr_bridge`

## Requirements
- R1: After reset the block is idle, with `req_ready`=1, `done`=0 and `win_valid`=0.
- R2: Every PHY register access is a pair of window transfers. The first writes the word `((dev & 0x1f) << 7) | ((addr >> 9) & 0x7f)` to window byte offset 0x800. The second accesses window byte offset `(addr & 0x1ff) << 2`, where `dev` is the port's table entry.
- R3: A read request performs these steps in order: wait until not busy, write the target address to the address register, write the start word, wait until not busy, then read the data register.
- R4: A write request performs these steps in order: wait until not busy, write the target address, write the data to the data register, then write the start word. It completes right after the start word, with no busy wait.
- R5: The control register is at PHY address 0x80a0, the address register at 0x80a1 and the data register at 0x80a2. The start word is 1 for a read and 3 for a write: bit 0 is start, bit 1 is the write flag.
- R6: A busy wait reads the control register repeatedly while bit 0 reads as 1. The wait ends on the first read with bit 0 equal to 0.
- R7: Suppose a busy wait sees L consecutive busy reads, where L is `poll_limit`, or 1 when `poll_limit` is 0. The request then ends with `done` and `timeout_err`=1, and no further window transfer is made for it. `timeout_err` is never 1 without `done`.
- R8: Writing the table with `tbl_we` stores `tbl_dev` and `tbl_lane` for port `tbl_port`. A request to port p uses that port's device number and the target address `req_addr + lane*0x100` (modulo 2^16).
- R9: `req_ready` is low from the cycle after acceptance until `done`. `done` lasts one cycle and `req_ready` is high in the cycle after it. No window transfer takes place while the block is idle.
- R10: While `win_valid` is high and `win_ready` is low, `win_valid`, `win_write`, `win_addr` and `win_wdata` hold their values.
- R11: On `done` for a successful read, `rdata` equals bits 15:0 of the data register value returned by the final window read, and `timeout_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Port table write strobe |
| tbl_port | input | 5 | Table entry to write |
| tbl_dev | input | 5 | PHY device number for the entry |
| tbl_lane | input | 2 | Lane number for the entry |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_port | input | 5 | Port of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address, before lane offset |
| req_wdata | input | 16 | Write data |
| poll_limit | input | 16 | Busy reads allowed per wait, 0 treated as 1 |
| done | output | 1 | One-cycle completion strobe |
| rdata | output | 16 | Read result, valid with done |
| timeout_err | output | 1 | Busy wait gave up, valid with done |
| win_valid | output | 1 | Window transfer request |
| win_ready | input | 1 | Window transfer accepted this cycle |
| win_write | output | 1 | 1 = window write |
| win_addr | output | 12 | Window byte offset |
| win_wdata | output | 32 | Window write data |
| win_rdata | input | 32 | Window read data, valid when ready |

## Verification
The hardest situations to reach are the busy-wait edges. One is a wait that clears on exactly the last permitted poll. Another is a wait that runs out exactly at the limit. A third is a timeout in the second wait of a read, after the PHY has already accepted a start. The bench's PHY model holds a busy count that the stimulus presets before each request and reloads when a start word arrives. This lets each request place the busy count exactly at, one below or beyond the poll limit, in either wait. Window stalls from a ready pattern overlap these sequences, so the hold behaviour is exercised mid-sequence.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
   localparam int PHY_AW = 16;
   localparam int PHY_DW = 16;
   localparam int WIN_AW = 12;
   localparam int WIN_DW = 32;
   localparam int DEV_W  = 5;
   localparam int PAGE_W = 7;
   localparam int SLOT_W = 9;

   localparam logic [PHY_AW-1:0] CR_CTL = 16'h80a0;
   localparam logic [PHY_AW-1:0] CR_ADR = 16'h80a1;
   localparam logic [PHY_AW-1:0] CR_DAT = 16'h80a2;
   localparam logic [WIN_AW-1:0] MAP_OFF = 12'h800;
   localparam int BUSY_BIT = 0;
   localparam int WRITE_BIT = 1;

   typedef enum logic [2:0] {
      SQ_IDLE, SQ_POLL_PRE, SQ_ADDR, SQ_WDATA,
      SQ_START, SQ_POLL_POST, SQ_FETCH, SQ_DONE
   } sq_state_t;

   typedef enum logic [1:0] {WA_IDLE, WA_MAP, WA_DATA} wa_state_t;

   function automatic logic [WIN_DW-1:0] page_word(input logic [DEV_W-1:0] dev,
                                                   input logic [PHY_AW-1:0] a);
      return {{(WIN_DW-DEV_W-PAGE_W){1'b0}}, dev, a[PHY_AW-1:SLOT_W]};
   endfunction

   function automatic logic [WIN_AW-1:0] slot_offset(input logic [PHY_AW-1:0] a);
      return {{(WIN_AW-SLOT_W-2){1'b0}}, a[SLOT_W-1:0], 2'b00};
   endfunction
endpackage

// File: rtl/pcb_port_tbl.sv
module pcb_port_tbl
   import pcb_pkg::*;
#(
   parameter int PORTS  = 24,
   parameter int PORT_W = 5,
   parameter int LANE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PORT_W-1:0] wr_port,
   input  logic [DEV_W-1:0]  wr_dev,
   input  logic [LANE_W-1:0] wr_lane,
   input  logic [PORT_W-1:0] rd_port,
   output logic [DEV_W-1:0]  rd_dev,
   output logic [LANE_W-1:0] rd_lane
);
   logic [DEV_W-1:0]  dev_q  [PORTS];
   logic [LANE_W-1:0] lane_q [PORTS];

   for (genvar g = 0; g < PORTS; g++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            dev_q[g]  <= '0;
            lane_q[g] <= '0;
         end else if (wr_en && wr_port == PORT_W'(g)) begin
            dev_q[g]  <= wr_dev;
            lane_q[g] <= wr_lane;
         end
      end
   end

   always_comb begin
      rd_dev  = '0;
      rd_lane = '0;
      for (int i = 0; i < PORTS; i++) begin
         if (rd_port == PORT_W'(i)) begin
            rd_dev  = dev_q[i];
            rd_lane = lane_q[i];
         end
      end
   end
endmodule

// File: rtl/pcb_win_acc.sv
module pcb_win_acc
   import pcb_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_req,
   input  logic              acc_wr,
   input  logic [PHY_AW-1:0] acc_addr,
   input  logic [PHY_DW-1:0] acc_wdata,
   input  logic [DEV_W-1:0]  acc_dev,
   output logic              acc_done,
   output logic [PHY_DW-1:0] acc_rdata,
   output logic              win_valid,
   input  logic              win_ready,
   output logic              win_write,
   output logic [WIN_AW-1:0] win_addr,
   output logic [WIN_DW-1:0] win_wdata,
   input  logic [WIN_DW-1:0] win_rdata
);
   wa_state_t state;
   logic      unused_hi;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= WA_IDLE;
      end else begin
         unique case (state)
            WA_IDLE: if (acc_req)   state <= WA_MAP;
            WA_MAP:  if (win_ready) state <= WA_DATA;
            WA_DATA: if (win_ready) state <= WA_IDLE;
            default:                state <= WA_IDLE;
         endcase
      end
   end

   always_comb begin
      win_valid = (state != WA_IDLE);
      if (state == WA_MAP) begin
         win_write = 1'b1;
         win_addr  = MAP_OFF;
         win_wdata = page_word(acc_dev, acc_addr);
      end else begin
         win_write = acc_wr;
         win_addr  = slot_offset(acc_addr);
         win_wdata = {{(WIN_DW-PHY_DW){1'b0}}, acc_wdata};
      end
   end

   assign acc_done  = (state == WA_DATA) && win_ready;
   assign acc_rdata = win_rdata[PHY_DW-1:0];
   assign unused_hi = ^win_rdata[WIN_DW-1:PHY_DW];
endmodule

// File: rtl/pcb_seq.sv
module pcb_seq
   import pcb_pkg::*;
#(
   parameter int POLL_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [PHY_AW-1:0] tgt_addr,
   input  logic [PHY_DW-1:0] req_wdata,
   input  logic [DEV_W-1:0]  tgt_dev,
   input  logic [POLL_W-1:0] poll_limit,
   output logic              acc_req,
   output logic              acc_wr,
   output logic [PHY_AW-1:0] acc_addr,
   output logic [PHY_DW-1:0] acc_wdata,
   output logic [DEV_W-1:0]  acc_dev,
   input  logic              acc_done,
   input  logic [PHY_DW-1:0] acc_rdata,
   output logic              done,
   output logic              timeout_err,
   output logic [PHY_DW-1:0] rdata
);
   sq_state_t         state;
   logic              op_wr;
   logic [PHY_AW-1:0] op_addr;
   logic [PHY_DW-1:0] op_wdata;
   logic [DEV_W-1:0]  op_dev;
   logic [POLL_W-1:0] op_lim;
   logic [POLL_W-1:0] poll_cnt;
   logic              err_q;
   logic [PHY_DW-1:0] rdata_q;
   logic [POLL_W:0]   cnt_nx;
   logic [POLL_W:0]   lim_eff;
   logic [PHY_DW-1:0] start_word;

   assign cnt_nx  = {1'b0, poll_cnt} + 1'b1;
   assign lim_eff = (op_lim == '0) ? (POLL_W+1)'(1) : {1'b0, op_lim};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= SQ_IDLE;
         op_wr    <= 1'b0;
         op_addr  <= '0;
         op_wdata <= '0;
         op_dev   <= '0;
         op_lim   <= '0;
         poll_cnt <= '0;
         err_q    <= 1'b0;
         rdata_q  <= '0;
      end else begin
         unique case (state)
            SQ_IDLE: if (req_valid) begin
               op_wr    <= req_write;
               op_addr  <= tgt_addr;
               op_wdata <= req_wdata;
               op_dev   <= tgt_dev;
               op_lim   <= poll_limit;
               poll_cnt <= '0;
               err_q    <= 1'b0;
               state    <= SQ_POLL_PRE;
            end
            SQ_POLL_PRE, SQ_POLL_POST: if (acc_done) begin
               if (!acc_rdata[BUSY_BIT]) begin
                  poll_cnt <= '0;
                  state    <= (state == SQ_POLL_PRE) ? SQ_ADDR : SQ_FETCH;
               end else if (cnt_nx >= lim_eff) begin
                  err_q <= 1'b1;
                  state <= SQ_DONE;
               end else begin
                  poll_cnt <= cnt_nx[POLL_W-1:0];
               end
            end
            SQ_ADDR:  if (acc_done) state <= op_wr ? SQ_WDATA : SQ_START;
            SQ_WDATA: if (acc_done) state <= SQ_START;
            SQ_START: if (acc_done) state <= op_wr ? SQ_DONE : SQ_POLL_POST;
            SQ_FETCH: if (acc_done) begin
               rdata_q <= acc_rdata;
               state   <= SQ_DONE;
            end
            SQ_DONE:  state <= SQ_IDLE;
            default:  state <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      start_word            = '0;
      start_word[BUSY_BIT]  = 1'b1;
      start_word[WRITE_BIT] = op_wr;
   end

   always_comb begin
      acc_req   = 1'b0;
      acc_wr    = 1'b0;
      acc_addr  = CR_CTL;
      acc_wdata = '0;
      unique case (state)
         SQ_POLL_PRE, SQ_POLL_POST: acc_req = 1'b1;
         SQ_ADDR: begin
            acc_req = 1'b1; acc_wr = 1'b1; acc_addr = CR_ADR; acc_wdata = op_addr;
         end
         SQ_WDATA: begin
            acc_req = 1'b1; acc_wr = 1'b1; acc_addr = CR_DAT; acc_wdata = op_wdata;
         end
         SQ_START: begin
            acc_req = 1'b1; acc_wr = 1'b1; acc_wdata = start_word;
         end
         SQ_FETCH: begin
            acc_req = 1'b1; acc_addr = CR_DAT;
         end
         default: ;
      endcase
   end

   assign acc_dev     = op_dev;
   assign req_ready   = (state == SQ_IDLE);
   assign done        = (state == SQ_DONE);
   assign timeout_err = (state == SQ_DONE) && err_q;
   assign rdata       = rdata_q;
endmodule

// File: rtl/phy_cr_bridge.sv
module phy_cr_bridge
   import pcb_pkg::*;
#(
   parameter int PORTS      = 24,
   parameter int LANE_W     = 2,
   parameter int LANE_SHIFT = 8,
   parameter int POLL_W     = 16,
   localparam int PORT_W    = (PORTS > 1) ? $clog2(PORTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tbl_we,
   input  logic [PORT_W-1:0] tbl_port,
   input  logic [DEV_W-1:0]  tbl_dev,
   input  logic [LANE_W-1:0] tbl_lane,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [PORT_W-1:0] req_port,
   input  logic              req_write,
   input  logic [PHY_AW-1:0] req_addr,
   input  logic [PHY_DW-1:0] req_wdata,
   input  logic [POLL_W-1:0] poll_limit,
   output logic              done,
   output logic [PHY_DW-1:0] rdata,
   output logic              timeout_err,
   output logic              win_valid,
   input  logic              win_ready,
   output logic              win_write,
   output logic [WIN_AW-1:0] win_addr,
   output logic [WIN_DW-1:0] win_wdata,
   input  logic [WIN_DW-1:0] win_rdata
);
   if (PORTS < 1) begin : g_bad_ports
      $error("PORTS must be at least 1");
   end
   if (LANE_SHIFT + LANE_W > PHY_AW) begin : g_bad_lane
      $error("lane offset does not fit the PHY address");
   end
   if (POLL_W < 1) begin : g_bad_poll
      $error("POLL_W must be at least 1");
   end

   logic [DEV_W-1:0]  lk_dev;
   logic [LANE_W-1:0] lk_lane;
   logic [PHY_AW-1:0] tgt_addr;
   logic              acc_req, acc_wr, acc_done;
   logic [PHY_AW-1:0] acc_addr;
   logic [PHY_DW-1:0] acc_wdata, acc_rdata;
   logic [DEV_W-1:0]  acc_dev;

   assign tgt_addr = req_addr + (PHY_AW'(lk_lane) << LANE_SHIFT);

   pcb_port_tbl #(.PORTS(PORTS), .PORT_W(PORT_W), .LANE_W(LANE_W)) u_tbl (
      .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_port(tbl_port),
      .wr_dev(tbl_dev), .wr_lane(tbl_lane), .rd_port(req_port),
      .rd_dev(lk_dev), .rd_lane(lk_lane)
   );

   pcb_seq #(.POLL_W(POLL_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .tgt_addr(tgt_addr), .req_wdata(req_wdata),
      .tgt_dev(lk_dev), .poll_limit(poll_limit), .acc_req(acc_req),
      .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
      .acc_dev(acc_dev), .acc_done(acc_done), .acc_rdata(acc_rdata),
      .done(done), .timeout_err(timeout_err), .rdata(rdata)
   );

   pcb_win_acc u_win (
      .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_wr(acc_wr),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_dev(acc_dev),
      .acc_done(acc_done), .acc_rdata(acc_rdata), .win_valid(win_valid),
      .win_ready(win_ready), .win_write(win_write), .win_addr(win_addr),
      .win_wdata(win_wdata), .win_rdata(win_rdata)
   );
endmodule

// File: rtl/pcb_bridge_chk.sv
module pcb_bridge_chk
   import pcb_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              done,
   input logic              timeout_err,
   input logic              win_valid,
   input logic              win_ready,
   input logic              win_write,
   input logic [WIN_AW-1:0] win_addr,
   input logic [WIN_DW-1:0] win_wdata
);
   logic prev_map;

   always_ff @(posedge clk) begin
      if (!rst_n)                       prev_map <= 1'b0;
      else if (win_valid && win_ready)  prev_map <= (win_addr == MAP_OFF);
   end

   AST_MAP_BEFORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && win_ready && win_addr != MAP_OFF) |-> prev_map); // R2
   AST_MAP_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && win_addr == MAP_OFF) |-> win_write); // R2
   AST_TIMEOUT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_err |-> done); // R7
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> req_ready); // R9
   AST_IDLE_NO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !win_valid); // R9
   AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && !win_ready) |=> (win_valid && $stable(win_addr)
                                     && $stable(win_write) && $stable(win_wdata))); // R10
endmodule

bind phy_cr_bridge pcb_bridge_chk u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
   .timeout_err(timeout_err), .win_valid(win_valid), .win_ready(win_ready),
   .win_write(win_write), .win_addr(win_addr), .win_wdata(win_wdata)
);

// File: tb/phy_cr_bridge_tb.sv
module phy_cr_bridge_tb;
   import pcb_pkg::*;
   localparam int CLK_PERIOD = 10;
   localparam int PORT_W = 5;
   localparam int POLL_W = 16;

   logic clk = 1'b0;
   logic rst_n;
   logic tbl_we;
   logic [PORT_W-1:0] tbl_port;
   logic [DEV_W-1:0] tbl_dev;
   logic [1:0] tbl_lane;
   logic req_valid, req_write;
   logic req_ready, done, timeout_err;
   logic [PORT_W-1:0] req_port;
   logic [PHY_AW-1:0] req_addr;
   logic [PHY_DW-1:0] req_wdata, rdata;
   logic [POLL_W-1:0] poll_limit;
   logic win_valid, win_write;
   logic win_ready = 1'b0;
   logic [WIN_AW-1:0] win_addr;
   logic [WIN_DW-1:0] win_wdata;
   logic [WIN_DW-1:0] win_rdata = '0;

   int t_cmp = 0, t_bad = 0, m_cmp = 0, m_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   phy_cr_bridge u_dut (
      .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_port(tbl_port),
      .tbl_dev(tbl_dev), .tbl_lane(tbl_lane), .req_valid(req_valid),
      .req_ready(req_ready), .req_port(req_port), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .poll_limit(poll_limit),
      .done(done), .rdata(rdata), .timeout_err(timeout_err),
      .win_valid(win_valid), .win_ready(win_ready), .win_write(win_write),
      .win_addr(win_addr), .win_wdata(win_wdata), .win_rdata(win_rdata)
   );

   // expected window transfers: written by the stimulus, consumed by the model
   logic        exp_w [0:255];
   logic [11:0] exp_a [0:255];
   logic [31:0] exp_d [0:255];
   logic        exp_c [0:255];
   int          exp_t [0:255];
   int wr_ptr = 0;
   int rd_ptr = 0;

   // PHY model state
   logic [15:0] phy_mem [logic [15:0]];
   logic [15:0] shadow  [logic [15:0]];
   logic [31:0] map_q = '0;
   logic [15:0] cr_addr = '0, cr_data = '0;
   int busy_cnt = 0, cfg_pre = 0, cfg_post = 0, stall_mode = 0, cyc = 0;
   logic x_v = 1'b0, x_w = 1'b0, x_acc = 1'b0;
   logic [11:0] x_a = '0;
   logic [31:0] x_d = '0;

   int dev_m [0:31];
   int lane_m [0:31];

   function automatic logic [15:0] mem_get(input logic [15:0] k);
      return phy_mem.exists(k) ? phy_mem[k] : 16'h0;
   endfunction

   function automatic logic [15:0] shd_get(input logic [15:0] k);
      return shadow.exists(k) ? shadow[k] : 16'h0;
   endfunction

   always @(posedge clk) begin
      x_v   <= win_valid && win_ready;
      x_w   <= win_write;
      x_a   <= win_addr;
      x_d   <= win_wdata;
      x_acc <= req_valid && req_ready && rst_n;
   end

   always @(negedge clk) begin : p_model
      logic [15:0] ia;
      int k;
      cyc++;
      if (x_acc) busy_cnt = cfg_pre;
      if (x_v) begin
         m_cmp++;
         if (rd_ptr == wr_ptr) begin
            m_bad++;
            $display("FAIL R9 unexpected window transfer: got a=%h w=%0b expected none", x_a, x_w);
         end else begin
            k = rd_ptr % 256;
            if (x_w !== exp_w[k] || x_a !== exp_a[k] || (exp_c[k] && x_d !== exp_d[k])) begin
               m_bad++;
               $display("FAIL R%0d transfer %0d: got w=%0b a=%h d=%h expected w=%0b a=%h d=%h",
                        exp_t[k], rd_ptr, x_w, x_a, x_d, exp_w[k], exp_a[k], exp_d[k]);
            end
            rd_ptr++;
         end
         if (x_w && x_a == MAP_OFF) begin
            map_q = x_d;
         end else begin
            ia = {map_q[6:0], x_a[10:2]};
            if (x_w) begin
               if (ia == CR_ADR) cr_addr = x_d[15:0];
               else if (ia == CR_DAT) cr_data = x_d[15:0];
               else if (ia == CR_CTL && x_d[0]) begin
                  if (x_d[1]) phy_mem[cr_addr] = cr_data;
                  else        cr_data = mem_get(cr_addr);
                  busy_cnt = cfg_post;
               end
            end else if (ia == CR_CTL && busy_cnt > 0) begin
               busy_cnt--;
            end
         end
      end
      win_ready = (stall_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
      ia = {map_q[6:0], win_addr[10:2]};
      if (ia == CR_CTL)      win_rdata = {31'h0, busy_cnt != 0};
      else if (ia == CR_DAT) win_rdata = {16'h0, cr_data};
      else                   win_rdata = {16'h0, mem_get(ia)};
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
      t_cmp++;
      if (!ok) begin
         t_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic push_one(input bit w, input int off, input int d, input bit c, input int tag);
      int k = wr_ptr % 256;
      exp_w[k] = w; exp_a[k] = 12'(off); exp_d[k] = 32'(d); exp_c[k] = c; exp_t[k] = tag;
      wr_ptr++;
   endtask

   // R2 framing: page word to 0x800, then the slot offset
   task automatic push_acc(input bit w, input int dev, input int a, input int d, input bit c, input int tag);
      push_one(1'b1, 'h800, ((dev & 'h1f) << 7) | ((a >> 9) & 'h7f), 1'b1, 2);
      push_one(w, (a & 'h1ff) << 2, d & 'hffff, c, tag);
   endtask

   // R6 / R7: polls until clear or limit reached
   task automatic push_polls(input int dev, input int b, input int lim, output bit to);
      int le = (lim == 0) ? 1 : lim;
      int n = (b >= le) ? le : b + 1;
      for (int i = 0; i < n; i++) push_acc(1'b0, dev, 'h80a0, 0, 1'b0, 6);
      to = (b >= le);
   endtask

   task automatic tbl_set(input int p, input int dev, input int lane);
      tbl_we = 1'b1; tbl_port = PORT_W'(p); tbl_dev = DEV_W'(dev); tbl_lane = 2'(lane);
      dev_m[p] = dev; lane_m[p] = lane;
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   task automatic run_op(input int port, input bit wr, input int addr, input int wd,
                         input int pre, input int post, input int lim);
      int dev = dev_m[port];
      int eff = (addr + lane_m[port] * 256) & 'hffff;
      bit to = 1'b0;
      bit exp_err;
      logic [15:0] exp_rd = '0;
      int n = 0;
      bit bad_rdy = 1'b0;
      push_polls(dev, pre, lim, to);
      if (!to) begin
         if (wr) begin
            push_acc(1'b1, dev, 'h80a1, eff, 1'b1, 4);
            push_acc(1'b1, dev, 'h80a2, wd, 1'b1, 4);
            push_acc(1'b1, dev, 'h80a0, 3, 1'b1, 5);
            shadow[16'(eff)] = 16'(wd);
         end else begin
            push_acc(1'b1, dev, 'h80a1, eff, 1'b1, 3);
            push_acc(1'b1, dev, 'h80a0, 1, 1'b1, 5);
            push_polls(dev, post, lim, to);
            if (!to) begin
               push_acc(1'b0, dev, 'h80a2, 0, 1'b0, 3);
               exp_rd = shd_get(16'(eff));
            end
         end
      end
      exp_err = to;
      cfg_pre = pre; cfg_post = post;
      poll_limit = POLL_W'(lim);
      req_port = PORT_W'(port); req_write = wr;
      req_addr = 16'(addr); req_wdata = 16'(wd); req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready === 1'b0, "R9 ready low after accept", 32'(req_ready), 0);
      while (done !== 1'b1 && n < 3000) begin
         @(negedge clk);
         n++;
         if (done !== 1'b1 && req_ready !== 1'b0) bad_rdy = 1'b1;
      end
      chk(n < 3000, "R9 watchdog on done", n, 0);
      chk(!bad_rdy, "R9 ready stayed low while busy", 32'(bad_rdy), 0);
      chk(timeout_err === exp_err, "R7 timeout flag", 32'(timeout_err), 32'(exp_err));
      if (!wr && !exp_err) chk(rdata === exp_rd, "R11 read data", 32'(rdata), 32'(exp_rd));
      @(negedge clk);
      chk(done === 1'b0 && req_ready === 1'b1, "R9 done lasts one cycle",
          {30'h0, done, req_ready}, 32'h1);
      chk(rd_ptr == wr_ptr, wr ? "R4 write sequence complete" : "R3 read sequence complete",
          rd_ptr, wr_ptr);
   endtask

   initial begin : p_watchdog
      repeat (150000) @(posedge clk);
      $display("FAIL R9 watchdog: got no finish expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", t_cmp + m_cmp + 1, t_bad + m_bad + 1);
      $finish;
   end

   initial begin : p_stim
      for (int i = 0; i < 32; i++) begin dev_m[i] = 0; lane_m[i] = 0; end
      rst_n = 1'b0; tbl_we = 1'b0; tbl_port = '0; tbl_dev = '0; tbl_lane = '0;
      req_valid = 1'b0; req_write = 1'b0; req_port = '0; req_addr = '0;
      req_wdata = '0; poll_limit = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready === 1'b1 && done === 1'b0 && win_valid === 1'b0, "R1 reset state",
          {29'h0, req_ready, done, win_valid}, 32'h4);

      // R8: table loading
      tbl_set(0, 3, 0);
      tbl_set(5, 17, 2);
      tbl_set(23, 31, 3);
      tbl_set(9, 0, 1);

      run_op(0, 1'b1, 'h2005, 'hbeef, 0, 2, 8);   // R4 R5 plain write
      run_op(0, 1'b0, 'h2005, 0, 2, 3, 8);        // R3 R6 R11 read with busy waits
      stall_mode = 1;                              // R10 window stalls
      run_op(5, 1'b1, 'h0123, 'h1234, 1, 0, 8);   // R8 lane 2 offset
      run_op(5, 1'b0, 'h0123, 0, 0, 1, 8);
      run_op(23, 1'b1, 'h7fff, 'ha5a5, 0, 0, 8);  // R2 high page bits, lane 3
      run_op(23, 1'b0, 'h7fff, 0, 3, 2, 8);
      run_op(0, 1'b0, 'h2123, 0, 0, 0, 8);        // R11 unwritten register reads 0
      stall_mode = 0;
      run_op(9, 1'b0, 'h0040, 0, 5, 0, 3);        // R7 timeout in first wait
      run_op(0, 1'b0, 'h2005, 0, 0, 10, 4);       // R7 timeout in second wait
      run_op(9, 1'b1, 'h0040, 'h0bad, 1, 0, 0);   // R7 limit 0 acts as 1
      run_op(9, 1'b1, 'h0041, 'h5a5a, 4, 0, 5);   // R6 clears on last allowed poll
      run_op(9, 1'b0, 'h0041, 0, 4, 0, 4);        // R7 busy equals limit
      run_op(9, 1'b0, 'h0041, 0, 0, 4, 5);        // R6 second wait clears at limit-1
      tbl_set(0, 7, 1);                           // R8 table rewrite
      run_op(0, 1'b1, 'h1f00, 'h0f0f, 0, 0, 2);
      run_op(0, 1'b0, 'h1f00, 0, 1, 1, 2);
      repeat (3) @(negedge clk);
      chk(win_valid === 1'b0, "R9 idle without window traffic", 32'(win_valid), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", t_cmp + m_cmp, t_bad + m_bad);
      $finish;
   end
endmodule